// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block keeps time as a free-running 32-bit count of seconds and raises an interrupt when that count reaches a programmed 32-bit alarm value. Software reaches it through a byte-wide register bus with an address, write data, write and read strobes and a read-data return. A one-cycle pulse on the tick input, made elsewhere from a slow oscillator, advances the count by one.

A new time is not written straight into the counter. Software fills staging bytes, and a write to the low staging byte moves the whole word into the counter in one clock. Software first writes zero to the low byte, then the three upper bytes, then the real low byte, so the count cannot carry into a half-written word. The count bytes are read live with no snapshot. Software catches a carry that falls between byte reads by reading the low byte a second time and comparing. The interrupt is a level that is the AND of a sticky match flag and an enable bit, so each alarm gives exactly one rising edge.

Top module: `sec_rtc`

## Requirements
- R1: After reset the counter, the alarm value, all staging bytes, the control bits, the match flag and the read-data output are zero, and the interrupt is low.
- R2: While control bit 7 (run) at address 0x0 is 1, each tick pulse adds one to the counter. While it is 0, ticks are ignored and the count holds.
- R3: The counter wraps from 0xFFFFFFFF to 0x00000000 on a tick.
- R4: Every access moves one byte. A read strobe latches the byte at the address onto the read data at the next clock, where it stays until the next read. Multi-byte groups are little-endian, with the lowest address holding bits 7:0.
- R5: Addresses 0x6 to 0x9 return the live counter bytes with no snapshot. A carry out of the low byte between two reads shows as a smaller low byte on the second read.
- R6: Writes to addresses 0x3 to 0x5 only stage bytes 1 to 3 and leave the counter unchanged. A write to 0x2 loads {staged byte 3, 2, 1, written byte} into the counter in one clock. Staging bytes read back at 0x2 to 0x5.
- R7: A load in the same cycle as a tick wins over the tick, and no alarm match is taken on the loaded value.
- R8: Addresses 0xA to 0xD hold the 32-bit alarm value, both writable and readable.
- R9: When a tick makes the counter equal the alarm value while control bit 1 (alarm enable) is 1, the match flag (bit 0 at address 0x1) sets and stays set until software clears it.
- R10: A match reached while alarm enable is 0 does not set the flag.
- R11: A write to address 0x1 with bit 0 equal to 0 clears the flag. A write with bit 0 equal to 1 has no effect.
- R12: The interrupt output equals flag AND alarm enable, registered bits only. It falls on the clock that clears either bit and rises once per alarm event.
- R13: Unused control bits, unused flag-register bits and addresses 0xE and 0xF read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rdata | output | 8 | Read data, valid from the clock after the read strobe |
| tick | input | 1 | One-cycle pulse per elapsed second |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The bench loads 0x000001FF and reads the low byte, the next byte after a tick, and the low byte again. A design that snapshots the count on the first read would return a stale low byte and hide the carry. Loads are driven in the same cycle as a tick, using the alarm value itself. A design that lets the tick win would show the count one higher, and one that matches on the loaded value would raise a false interrupt. The interrupt is masked and unmasked while the flag stays pending, a flag write with bit 0 set is tried, a match is reached with the enable off, and the counter is taken through its wrap. A design that clears the flag on disable, clears it on any write, latches a match that was masked, or stops at all ones would diverge from the cycle model at once.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  // Fixed register slots; the groups after these follow from the byte count.
  localparam int unsigned CTRL_OFS  = 0;
  localparam int unsigned FLAG_OFS  = 1;
  localparam int unsigned STAGE_OFS = 2;
  // Bit positions decoded by software.
  localparam int RUN_BIT  = 7;
  localparam int AEN_BIT  = 1;
  localparam int FLAG_BIT = 0;
endpackage

// File: rtl/sec_rtc_regfile.sv
module sec_rtc_regfile
  import sec_rtc_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [7:0]           rdata,
  input  logic [8*BYTES-1:0]   count_i,
  input  logic                 flag_i,
  output logic                 run_o,
  output logic                 aen_o,
  output logic                 load_o,
  output logic [8*BYTES-1:0]   load_val_o,
  output logic [8*BYTES-1:0]   alarm_val_o,
  output logic                 clr_o
);
  localparam int unsigned LIVE_OFS = STAGE_OFS + BYTES;
  localparam int unsigned AL_OFS   = LIVE_OFS + BYTES;

  logic       run_q, run_d, aen_q, aen_d;
  logic [7:0] stage_q [BYTES];
  logic [7:0] stage_d [BYTES];
  logic [7:0] alarm_q [BYTES];
  logic [7:0] alarm_d [BYTES];
  logic [7:0] rdata_q, rdata_d, rd_mux;
  logic [7:0] ctrl_byte, flag_byte;

  // next state for control, staging and alarm bytes
  always_comb begin
    run_d = run_q;
    aen_d = aen_q;
    if (wr_en && addr == ADDR_W'(CTRL_OFS)) begin
      run_d = wdata[RUN_BIT];
      aen_d = wdata[AEN_BIT];
    end
    for (int i = 0; i < BYTES; i++) begin
      stage_d[i] = stage_q[i];
      alarm_d[i] = alarm_q[i];
      if (wr_en && addr == ADDR_W'(STAGE_OFS + i)) stage_d[i] = wdata;
      if (wr_en && addr == ADDR_W'(AL_OFS + i))    alarm_d[i] = wdata;
    end
  end

  always_comb begin
    ctrl_byte = '0;
    ctrl_byte[RUN_BIT] = run_q;
    ctrl_byte[AEN_BIT] = aen_q;
    flag_byte = '0;
    flag_byte[FLAG_BIT] = flag_i;
  end

  // read selection from pre-write state
  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(CTRL_OFS)) rd_mux = ctrl_byte;
    if (addr == ADDR_W'(FLAG_OFS)) rd_mux = flag_byte;
    for (int i = 0; i < BYTES; i++) begin
      if (addr == ADDR_W'(STAGE_OFS + i)) rd_mux = stage_q[i];
      if (addr == ADDR_W'(LIVE_OFS + i))  rd_mux = count_i[8*i +: 8];
      if (addr == ADDR_W'(AL_OFS + i))    rd_mux = alarm_q[i];
    end
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      aen_q   <= 1'b0;
      rdata_q <= '0;
      for (int i = 0; i < BYTES; i++) begin
        stage_q[i] <= '0;
        alarm_q[i] <= '0;
      end
    end else begin
      run_q   <= run_d;
      aen_q   <= aen_d;
      rdata_q <= rdata_d;
      for (int i = 0; i < BYTES; i++) begin
        stage_q[i] <= stage_d[i];
        alarm_q[i] <= alarm_d[i];
      end
    end
  end

  generate
    for (genvar g = 0; g < BYTES; g++) begin : g_bytes
      assign alarm_val_o[8*g +: 8] = alarm_q[g];
      if (g == 0) begin : g_low
        assign load_val_o[7:0] = wdata;
      end else begin : g_up
        assign load_val_o[8*g +: 8] = stage_q[g];
      end
    end
  endgenerate

  assign load_o = wr_en && addr == ADDR_W'(STAGE_OFS);
  assign clr_o  = wr_en && addr == ADDR_W'(FLAG_OFS) && !wdata[FLAG_BIT];
  assign run_o  = run_q;
  assign aen_o  = aen_q;
  assign rdata  = rdata_q;

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] alarm_i,
  output logic [W-1:0] count_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_d, cnt_inc;
  logic         step;

  assign step    = tick_i && run_i;
  assign cnt_inc = cnt_q + W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)    cnt_d = load_val_i;
    else if (step) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // a match is taken only on a tick, never on a load
  assign hit_o   = step && !load_i && (cnt_inc == alarm_i);
  assign count_o = cnt_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step) |=> $stable(cnt_q));
  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_i && cnt_q == '1) |=> cnt_q == '0);
endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic aen_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d, set;

  assign set = hit_i && aen_i;

  // a new event wins over a clear in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (set)        flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && aen_i;

  // R9
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit_i && aen_i));
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit_i) |=> !flag_q);
  // R10
  masked_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !aen_i && !flag_q && !clr_i) |=> !flag_q);
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int BYTES  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  input  logic              tick,
  output logic              alarm_irq
);
  localparam int W = 8 * BYTES;

  logic [1:0]   rst_sync;
  logic         rst_sn;
  logic         run_w, aen_w, load_w, clr_w, hit_w, flag_w;
  logic [W-1:0] count_w, load_val_w, alarm_val_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  sec_rtc_regfile #(.BYTES(BYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sn), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .count_i(count_w), .flag_i(flag_w),
    .run_o(run_w), .aen_o(aen_w), .load_o(load_w),
    .load_val_o(load_val_w), .alarm_val_o(alarm_val_w), .clr_o(clr_w)
  );

  sec_rtc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .tick_i(tick), .run_i(run_w),
    .load_i(load_w), .load_val_i(load_val_w), .alarm_i(alarm_val_w),
    .count_o(count_w), .hit_o(hit_w)
  );

  sec_rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_sn), .hit_i(hit_w), .aen_i(aen_w),
    .clr_i(clr_w), .flag_o(flag_w), .irq_o(alarm_irq)
  );

  // R12
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(aen_w) |-> !alarm_irq);
  // R12
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(alarm_irq) |-> (flag_w && aen_w));
endmodule

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       wr_en, rd_en, tick;
  logic [7:0] rdata;
  logic       alarm_irq;

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  sec_rtc u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .tick(tick), .alarm_irq(alarm_irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_cnt, m_alarm;
  logic [31:0] m_stage;
  logic        m_run, m_aen, m_flag;
  logic [7:0]  m_rdata;

  function automatic logic [7:0] m_read(input int a);
    case (a)
      0:              return {m_run, 5'd0, m_aen, 1'b0};
      1:              return {7'd0, m_flag};
      2, 3, 4, 5:     return m_stage[8*(a-2) +: 8];
      6, 7, 8, 9:     return m_cnt[8*(a-6) +: 8];
      10, 11, 12, 13: return m_alarm[8*(a-10) +: 8];
      default:        return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_alarm = 0; m_stage = 0;
      m_run = 0; m_aen = 0; m_flag = 0; m_rdata = 0;
    end else begin
      bit hit;
      hit = 0;
      if (rd_en) m_rdata = m_read(int'(addr));
      if (wr_en && addr == 4'd2)
        m_cnt = {m_stage[31:8], wdata};
      else if (tick && m_run) begin
        m_cnt = m_cnt + 1;
        if (m_aen && m_cnt == m_alarm) hit = 1;
      end
      if (hit) m_flag = 1;
      else if (wr_en && addr == 4'd1 && !wdata[0]) m_flag = 0;
      if (wr_en) begin
        if (addr == 4'd0) begin m_run = wdata[7]; m_aen = wdata[1]; end
        if (addr >= 4'd2 && addr <= 4'd5) m_stage[8*(int'(addr)-2) +: 8] = wdata;
        if (addr >= 4'd10 && addr <= 4'd13) m_alarm[8*(int'(addr)-10) +: 8] = wdata;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rdata !== m_rdata || alarm_irq !== (m_flag && m_aen)) begin
        fails++;
        $display("FAIL %s: cycle compare rdata=%h irq=%b expected rdata=%h irq=%b",
                 cur_req, rdata, alarm_irq, m_rdata, m_flag && m_aen);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_tick(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(v, e, tag);
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic load32(input logic [31:0] v);
    wr(4'd2, 8'h00);
    wr(4'd3, v[15:8]);
    wr(4'd4, v[23:16]);
    wr(4'd5, v[31:24]);
    wr(4'd2, v[7:0]);
  endtask

  task automatic expect_count(input logic [31:0] v, input string tag);
    for (int b = 0; b < 4; b++) expect_rd(4'(6 + b), v[8*b +: 8], tag);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] v;
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R1";
    chk({7'd0, alarm_irq}, 8'h00, "R1 irq after reset");
    chk(rdata, 8'h00, "R1 rdata after reset");
    for (int a = 0; a < 14; a++) expect_rd(4'(a), 8'h00, "R1 register zero");
    cur_req = "R13";
    expect_rd(4'hE, 8'h00, "R13 reserved 0xE");
    expect_rd(4'hF, 8'h00, "R13 reserved 0xF");

    cur_req = "R2";
    pulse(3);
    expect_count(32'h0, "R2 ticks ignored while stopped");
    wr(4'd0, 8'hFF);
    expect_rd(4'd0, 8'h82, "R13 unused control bits read zero");
    wr(4'd0, 8'h80);
    pulse(5);
    expect_count(32'h5, "R2 five ticks counted");

    cur_req = "R6";
    wr(4'd2, 8'h00);
    wr(4'd3, 8'h22);
    wr(4'd4, 8'h33);
    wr(4'd5, 8'h44);
    expect_count(32'h0, "R6 staging leaves counter");
    expect_rd(4'd4, 8'h33, "R6 staging byte readback");
    wr(4'd2, 8'h11);
    cur_req = "R4";
    expect_count(32'h44332211, "R4 R6 little-endian load");

    cur_req = "R3";
    load32(32'hFFFFFFFE);
    pulse(1);
    expect_count(32'hFFFFFFFF, "R3 before wrap");
    pulse(1);
    expect_count(32'h0, "R3 wrap to zero");

    cur_req = "R5";
    load32(32'h000001FF);
    expect_rd(4'd6, 8'hFF, "R5 first low byte");
    pulse(1);
    expect_rd(4'd7, 8'h02, "R5 live upper byte after carry");
    rd(4'd6, v);
    chk(v, 8'h00, "R5 second low byte smaller");

    cur_req = "R8";
    wr(4'd10, 8'h10); wr(4'd11, 8'h00); wr(4'd12, 8'h00); wr(4'd13, 8'h00);
    expect_rd(4'd10, 8'h10, "R8 alarm byte 0");
    expect_rd(4'd13, 8'h00, "R8 alarm byte 3");

    cur_req = "R9";
    load32(32'h0000000E);
    wr(4'd0, 8'h82);
    pulse(1);
    chk({7'd0, alarm_irq}, 8'h00, "R9 no irq before match");
    pulse(1);
    chk({7'd0, alarm_irq}, 8'h01, "R9 irq at match");
    pulse(2);
    expect_rd(4'd1, 8'h01, "R9 flag sticky");

    cur_req = "R12";
    wr(4'd0, 8'h80);
    chk({7'd0, alarm_irq}, 8'h00, "R12 irq drops on disable");
    expect_rd(4'd1, 8'h01, "R12 flag kept while masked");
    wr(4'd0, 8'h82);
    chk({7'd0, alarm_irq}, 8'h01, "R12 irq back on enable");
    cur_req = "R11";
    wr(4'd1, 8'h01);
    chk({7'd0, alarm_irq}, 8'h01, "R11 write of one ignored");
    wr(4'd1, 8'hFE);
    chk({7'd0, alarm_irq}, 8'h00, "R11 R12 clear drops irq");
    expect_rd(4'd1, 8'h00, "R11 flag cleared");

    cur_req = "R10";
    wr(4'd0, 8'h80);
    load32(32'h0000000F);
    pulse(1);
    wr(4'd0, 8'h82);
    chk({7'd0, alarm_irq}, 8'h00, "R10 masked match not latched");
    expect_rd(4'd1, 8'h00, "R10 flag stays clear");

    cur_req = "R7";
    wr(4'd3, 8'h00); wr(4'd4, 8'h00); wr(4'd5, 8'h00);
    wr_tick(4'd2, 8'h10);
    expect_count(32'h10, "R7 load wins over tick");
    chk({7'd0, alarm_irq}, 8'h00, "R7 no match on loaded value");
    wr_tick(4'd2, 8'h0F);
    pulse(1);
    chk({7'd0, alarm_irq}, 8'h01, "R7 R9 match after load then tick");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule